// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block sits between a set of raw wake-capable interrupt lines and a parent interrupt controller. The parent accepts only two forms of input: an active-high level or a rising edge. Each pin carries a 3-bit trigger code and an enable. The block synchronizes the raw line and inverts it when the source is active-low or falling-edge. Edge sources become one-cycle pulses, so the parent always sees a rising transition. A dual-edge source gives one pulse for each transition in either direction.

Software programs the pins through a word-addressed register port. Each pin has its own 32-bit configuration word. A read-only version word reports the hardware revision, and that revision decides where the enables live. On older revisions the enables are packed into shared bank words. On newer revisions each enable is a bit of the pin's own configuration word. The revision is fixed when the block is built.

Changing a pin's trigger code while its input is steady produces no pulse, so software does not have to clear a spurious event. Re-enabling a pin does not turn transitions that happened while it was disabled into a pulse.

Top module: `wake_polarity_norm`

## Requirements
- R1: After reset every output is low, every configuration word reads 0 and every enable is 0.
- R2: The configuration word of pin i is at word address 0x44+i (byte 0x110+4*i) and the trigger code is bits [2:0]. A read returns the last 32-bit value written, and a word changes only when it is written.
- R3: Word address 0x400 (byte 0x1000) reads the VERSION parameter, and writes to it have no effect. Revision 3.2 is encoded as 0x30200.
- R4: When VERSION is below 0x30200, the enable of pin p is bit p%32 of bank word 0x4+p/32 (byte 0x10+4*(p/32)). Bit 3 of the configuration word then has no effect.
- R5: When VERSION is 0x30200 or above, bit 3 of the pin's configuration word is its enable. Writes to the bank words are ignored and those words read 0.
- R6: Code 100 (level, active high) drives the output with the synchronized input. A change at the input appears on the output after the third rising clock edge.
- R7: Code 000 (level, active low) drives the output with the inverted synchronized input.
- R8: Code 110 (rising edge) gives exactly one one-cycle pulse for each 0-to-1 input transition and no pulse when the input falls.
- R9: Code 010 (falling edge) gives exactly one one-cycle pulse for each 1-to-0 input transition and no pulse when the input rises.
- R10: Code 111 (dual edge) gives exactly one one-cycle pulse for each input transition in either direction.
- R11: A disabled pin drives its output low from the cycle after the enable clears. Enabling it does not create a pulse from input changes made while it was disabled.
- R12: Rewriting the trigger code while the input is steady creates no edge pulse.
- R13: The reserved codes 001, 011 and 101 hold the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Word address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for the word at addr |
| irq_in | input | NUM_PINS | Raw interrupt lines, asynchronous |
| irq_out | output | NUM_PINS | Conditioned lines to the parent controller |

## Verification
The bench drives two instances, one per revision, from the same register bus, so a single write to a bank word can be checked for effect on one revision and for being ignored on the other. It counts output pulses over a fixed window after each transition. That count catches a detector that fires on the wrong edge, misses the second edge of a dual source, or stretches a pulse. The riskiest cases are retyping a pin with its input steady and re-enabling a pin whose input moved while it was off. A design that kept its edge history in normalized polarity, or that froze it while the pin was disabled, would emit a phantom pulse in those cases. The bench also checks reserved codes and the legacy-revision case where bit 3 of the configuration word must do nothing.

// File: rtl/wake_norm_pkg.sv
package wake_norm_pkg;
  localparam logic [2:0] TRIG_LVL_LO = 3'b000;
  localparam logic [2:0] TRIG_FALL   = 3'b010;
  localparam logic [2:0] TRIG_LVL_HI = 3'b100;
  localparam logic [2:0] TRIG_RISE   = 3'b110;
  localparam logic [2:0] TRIG_BOTH   = 3'b111;

  localparam int unsigned BANK_WORD_BASE = 'h4;
  localparam int unsigned CFG_WORD_BASE  = 'h44;
  localparam int unsigned VER_WORD       = 'h400;
  localparam logic [31:0] VER_SPLIT      = 32'h0003_0200;
  localparam int unsigned CFG_EN_BIT     = 3;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/wake_regfile.sv
module wake_regfile
  import wake_norm_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [31:0] VERSION  = 32'h0003_0200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wr_data,
  output logic [31:0]              rd_data,
  output logic [NUM_PINS-1:0][2:0] pin_type,
  output logic [NUM_PINS-1:0]      pin_en
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + 31) / 32;
  localparam bit          LEGACY    = (VERSION < VER_SPLIT);

  logic [NUM_PINS-1:0][31:0] cfg_q, cfg_d;
  logic [NUM_PINS-1:0]       en_q, en_d;
  logic                      bank_hit;

  always_comb begin
    bank_hit = (addr >= ADDR_W'(BANK_WORD_BASE)) &&
               (addr <  ADDR_W'(BANK_WORD_BASE + NUM_BANKS));
  end

  // next state
  always_comb begin
    cfg_d = cfg_q;
    en_d  = en_q;
    if (wr_en) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (addr == ADDR_W'(CFG_WORD_BASE + i)) cfg_d[i] = wr_data;
        if (LEGACY && (addr == ADDR_W'(BANK_WORD_BASE + i / 32)))
          en_d[i] = wr_data[i % 32];
      end
    end
  end

  // registers, clock-enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
      en_q  <= en_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(VER_WORD)) rd_data = VERSION;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (addr == ADDR_W'(CFG_WORD_BASE + i)) rd_data = cfg_q[i];
      if (LEGACY && (addr == ADDR_W'(BANK_WORD_BASE + i / 32)))
        rd_data[i % 32] = en_q[i];
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign pin_type[g] = cfg_q[g][2:0];
    if (LEGACY) begin : g_bank_en
      assign pin_en[g] = en_q[g];
    end else begin : g_cfg_en
      assign pin_en[g] = cfg_q[g][CFG_EN_BIT];
    end
  end

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

  if (!LEGACY) begin : g_new_chk
    assert_bank_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bank_hit) |=> $stable(pin_en));
  end else begin : g_old_chk
    assert_bank_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !bank_hit) |=> $stable(pin_en));
  end
endmodule

// File: rtl/wake_pin_cond.sv
module wake_pin_cond
  import wake_norm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  logic [2:0] type_i,
  input  logic       en_i,
  output logic       out_o
);
  logic prev_q;
  logic out_q, out_d;
  logic invert, now_n, prev_n, hit;

  // Edge history is kept in raw polarity, so a type change never fakes an edge.
  always_comb begin
    invert = (type_i == TRIG_LVL_LO) || (type_i == TRIG_FALL);
    now_n  = sync_i ^ invert;
    prev_n = prev_q ^ invert;
    unique case (type_i)
      TRIG_LVL_LO, TRIG_LVL_HI: hit = now_n;
      TRIG_FALL, TRIG_RISE:     hit = now_n & ~prev_n;
      TRIG_BOTH:                hit = sync_i ^ prev_q;
      default:                  hit = 1'b0;
    endcase
    out_d = en_i & hit;
  end

  // History tracks the input even while disabled: no stale edge on enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      prev_q <= sync_i;
      out_q  <= out_d;
    end
  end

  assign out_o = out_q;

  assert_disabled_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !out_q);

  assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && type_i == TRIG_RISE) |=> (!out_q || type_i != TRIG_RISE));

  assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && type_i == TRIG_LVL_HI) |=> (out_q == $past(sync_i)));

  assert_reserved_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (type_i == 3'b001 || type_i == 3'b011 || type_i == 3'b101) |=> !out_q);
endmodule

// File: rtl/wake_polarity_norm.sv
module wake_polarity_norm
  import wake_norm_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [31:0] VERSION  = 32'h0003_0200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wr_data,
  output logic [31:0]         rd_data,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic [NUM_PINS-1:0] irq_out
);
  logic                      rst_meta_q, rst_sync_q;
  logic [NUM_PINS-1:0]       irq_sync;
  logic [NUM_PINS-1:0][2:0]  pin_type;
  logic [NUM_PINS-1:0]       pin_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  wake_regfile #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .VERSION  (VERSION)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .pin_type (pin_type),
    .pin_en   (pin_en)
  );

  wake_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_i   (irq_in),
    .q_o   (irq_sync)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cond
    wake_pin_cond u_cond (
      .clk    (clk),
      .rst_n  (rst_sync_q),
      .sync_i (irq_sync[g]),
      .type_i (pin_type[g]),
      .en_i   (pin_en[g]),
      .out_o  (irq_out[g])
    );
  end
endmodule

// File: tb/tb_wake_polarity_norm.sv
module tb_wake_polarity_norm;
  localparam int unsigned NP = 40;
  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] A_BANK = AW'('h4);
  localparam logic [AW-1:0] A_CFG  = AW'('h44);
  localparam logic [AW-1:0] A_VER  = AW'('h400);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [31:0]   wr_data;
  logic [31:0]   rd_new, rd_old;
  logic [NP-1:0] irq_in;
  logic [NP-1:0] out_new, out_old;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wake_polarity_norm #(.NUM_PINS(NP), .ADDR_W(AW), .VERSION(32'h0003_0200)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_new), .irq_in(irq_in), .irq_out(out_new));

  wake_polarity_norm #(.NUM_PINS(NP), .ADDR_W(AW), .VERSION(32'h0002_0000)) dut_old (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_old), .irq_in(irq_in), .irq_out(out_old));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit old, output logic [31:0] d);
    addr = a;
    #2;
    d = old ? rd_old : rd_new;
  endtask

  task automatic count_hi(input int pin, input bit old, output int n);
    n = 0;
    repeat (6) begin
      step(1);
      if (old ? out_old[pin] : out_new[pin]) n++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 outputs new", 32'(out_new), 32'h0);
    check("R1 outputs old", 32'(out_old), 32'h0);
    rd(A_CFG + 7, 1'b0, d); check("R1 cfg reads 0", d, 32'h0);
    rd(A_BANK, 1'b1, d);    check("R1 bank reads 0", d, 32'h0);
    rd(A_VER, 1'b0, d);     check("R3 version new", d, 32'h0003_0200);
    rd(A_VER, 1'b1, d);     check("R3 version old", d, 32'h0002_0000);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(A_CFG + 5, 32'hABCD_1230);
    rd(A_CFG + 5, 1'b0, d); check("R2 full word readback", d, 32'hABCD_1230);
    rd(A_CFG + 4, 1'b0, d); check("R2 neighbour untouched", d, 32'h0);
    wr(A_CFG + 5, 32'h0);
    wr(A_VER, 32'h1234_5678);
    rd(A_VER, 1'b0, d); check("R3 version write ignored", d, 32'h0003_0200);
  endtask

  task automatic t_level;
    wr(A_CFG + 0, 32'h0C);
    irq_in[0] = 1'b1; step(2);
    check("R6 not yet after two edges", 32'(out_new[0]), 32'h0);
    step(1);
    check("R6 level high follows", 32'(out_new[0]), 32'h1);
    irq_in[0] = 1'b0; step(3);
    check("R6 level high drops", 32'(out_new[0]), 32'h0);
    wr(A_CFG + 1, 32'h08); step(1);
    check("R7 active low asserted", 32'(out_new[1]), 32'h1);
    irq_in[1] = 1'b1; step(3);
    check("R7 active low released", 32'(out_new[1]), 32'h0);
  endtask

  task automatic t_edges;
    int n;
    wr(A_CFG + 2, 32'h0E);
    irq_in[2] = 1'b1; count_hi(2, 1'b0, n); check("R8 rise pulse", n, 1);
    irq_in[2] = 1'b0; count_hi(2, 1'b0, n); check("R8 no pulse on fall", n, 0);
    wr(A_CFG + 3, 32'h0A);
    irq_in[3] = 1'b1; count_hi(3, 1'b0, n); check("R9 no pulse on rise", n, 0);
    irq_in[3] = 1'b0; count_hi(3, 1'b0, n); check("R9 fall pulse", n, 1);
    wr(A_CFG + 4, 32'h0F);
    irq_in[4] = 1'b1; count_hi(4, 1'b0, n); check("R10 dual on rise", n, 1);
    irq_in[4] = 1'b0; count_hi(4, 1'b0, n); check("R10 dual on fall", n, 1);
  endtask

  task automatic t_disable;
    int n;
    wr(A_CFG + 0, 32'h0C); irq_in[0] = 1'b1; step(3);
    wr(A_CFG + 0, 32'h04); step(1);
    check("R11 disable drops level", 32'(out_new[0]), 32'h0);
    wr(A_CFG + 2, 32'h06);
    irq_in[2] = 1'b1; count_hi(2, 1'b0, n); check("R11 disabled no pulse", n, 0);
    wr(A_CFG + 2, 32'h0E);
    count_hi(2, 1'b0, n); check("R11 enable no stale pulse", n, 0);
    irq_in[2] = 1'b0; step(4);
  endtask

  task automatic t_retype;
    int n;
    irq_in[6] = 1'b1; step(4);
    wr(A_CFG + 6, 32'h0E); count_hi(6, 1'b0, n); check("R12 set rise, input high", n, 0);
    wr(A_CFG + 6, 32'h0A); count_hi(6, 1'b0, n); check("R12 rise to fall, high", n, 0);
    wr(A_CFG + 6, 32'h0F); count_hi(6, 1'b0, n); check("R12 fall to dual, high", n, 0);
    irq_in[6] = 1'b0; count_hi(6, 1'b0, n);        check("R10 dual after retype", n, 1);
    wr(A_CFG + 6, 32'h0E); count_hi(6, 1'b0, n); check("R12 dual to rise, low", n, 0);
    wr(A_CFG + 6, 32'h0A); count_hi(6, 1'b0, n); check("R12 rise to fall, low", n, 0);
  endtask

  task automatic t_reserved;
    int n, m;
    foreach (m_codes[k]) begin
      wr(A_CFG + 7, m_codes[k]);
      irq_in[7] = ~irq_in[7]; count_hi(7, 1'b0, n);
      irq_in[7] = ~irq_in[7]; count_hi(7, 1'b0, m);
      check("R13 reserved code silent", n + m, 0);
    end
  endtask

  logic [31:0] m_codes [3] = '{32'h09, 32'h0B, 32'h0D};

  task automatic t_versions;
    logic [31:0] d;
    wr(A_CFG + 33, 32'h0C); irq_in[33] = 1'b1; step(4);
    check("R4 cfg bit3 ignored on old", 32'(out_old[33]), 32'h0);
    check("R5 cfg bit3 enables on new", 32'(out_new[33]), 32'h1);
    wr(A_CFG + 8, 32'h04); irq_in[8] = 1'b1; step(3);
    wr(A_BANK, 32'hFFFF_FFFF); step(1);
    check("R5 bank write ignored on new", 32'(out_new[8]), 32'h0);
    rd(A_BANK, 1'b0, d); check("R5 bank reads 0 on new", d, 32'h0);
    wr(A_BANK, 32'h0);
    wr(A_BANK + 1, 32'h0000_0002); step(1);
    check("R4 bank bit enables pin 33", 32'(out_old[33]), 32'h1);
    rd(A_BANK + 1, 1'b1, d); check("R4 bank word readback", d, 32'h2);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0; irq_in = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_regmap();
    t_level();
    t_edges();
    t_disable();
    t_retype();
    t_reserved();
    t_versions();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule